// File: doc/BRIEF.md
# DRAM Refresh Cycle Decoder

This block observes the control strobes of a DRAM (row strobe, lower and upper column strobes, transfer/output enable, write enable), sampled once per system clock. Each RAS-low period is sorted into one of four kinds: a normal access, a CAS-before-RAS (CBR) refresh, a hidden refresh, or a RAS-only refresh. For refresh cycles it supplies the row to refresh and a strobe. The row comes from an internal wrapping counter, or from the external address in the RAS-only case.

CBR refreshes come in three variants, selected by a 2-bit code sampled when RAS falls. Only the option-reset variant clears the two persistent mode flags (write-per-bit and stop-point). The block keeps these flags, and software-side logic sets them through one-cycle set inputs. The block also produces an output-disable level for the data pins. That level follows the refresh kind: forced off for CBR, held valid for hidden refresh, and otherwise gated by CAS and TRG.

Top module: `dram_refresh_decoder`

## Requirements
- R1: A RAS falling edge is seen when `ras_n` is sampled low after being sampled high. From the next cycle `in_cycle`=1 and `cycle_kind` holds the class: 0 normal, 1 CBR (either CAS sampled low at the fall), 2 hidden, 3 RAS-only (both CAS high at the fall).
- R2: A cycle classed RAS-only becomes normal (code 0) one cycle after either CAS strobe is sampled low while RAS is still low.
- R3: Hidden refresh (code 2) is chosen at a RAS fall when both CAS strobes are low and have stayed low since the end of a normal cycle. That normal cycle must have ended, at the sampled RAS rise, with both CAS low and `we_n` high. The same holds for a hidden cycle ending with both CAS still low.
- R4: The refresh counter is `ROW_W` (9) bits wide and resets to 0. It increments by one at the end of each CBR or hidden cycle and wraps from 511 to 0. It does not change on normal or RAS-only cycles.
- R5: One cycle after the sampled RAS rise that ends a CBR, hidden or RAS-only cycle, `refresh_stb` pulses for one cycle and `in_cycle` drops. `refresh_row` then carries the counter value before the increment (CBR, hidden), or the `ext_row` value sampled at the fall (RAS-only). A normal cycle gives no strobe.
- R6: `cbr_sel` is sampled at the fall: 00 and 11 mean option reset, 01 and 10 mean no-reset. An option-reset CBR clears both mode flags and pulses `mode_clear` for one cycle after the fall. A no-reset CBR changes neither flag.
- R7: `set_wpb` / `set_stop` set their flag on the next cycle. If such a set arrives at the same edge as an option-reset fall, the flag ends up cleared.
- R8: `out_hiz` is 1 during a CBR cycle and 0 during a hidden cycle. During normal or RAS-only cycles it is 0 only while either CAS and `trg_n` are low. Outside any cycle it equals the inverse of the hidden-armed condition from R3.
- R9: With `rst_n` sampled low, the counter, both flags, strobes, `in_cycle`, `cycle_kind` and `refresh_row` clear to 0 and RAS is treated as high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Sampled row strobe, active low |
| casl_n | input | 1 | Sampled lower column strobe, active low |
| casu_n | input | 1 | Sampled upper column strobe, active low |
| trg_n | input | 1 | Sampled output enable / transfer strobe, active low |
| we_n | input | 1 | Sampled write enable, active low |
| cbr_sel | input | 2 | CBR variant code |
| ext_row | input | ROW_W | External row address |
| set_wpb | input | 1 | One-cycle set of write-per-bit flag |
| set_stop | input | 1 | One-cycle set of stop-point flag |
| in_cycle | output | 1 | RAS-low cycle in progress |
| cycle_kind | output | 2 | Class of current or last cycle |
| refresh_stb | output | 1 | One-cycle refresh strobe |
| refresh_row | output | ROW_W | Row refreshed with the strobe |
| mode_clear | output | 1 | One-cycle pulse when flags are cleared by CBR |
| wpb_on | output | 1 | Persistent write-per-bit flag |
| stop_on | output | 1 | Stop-point flag |
| out_hiz | output | 1 | Data outputs held high-impedance |

## Verification
On every cycle, the assertions check these points: a CBR class agrees with the CAS levels sampled at the fall, the counter only ever moves by one step, strobes never come back to back, and a `mode_clear` pulse always leaves both flags low. Other behaviours appear only in the bench's scenarios, where a behavioural reference model runs beside the design. These are the hidden-refresh arming chain across two RAS periods, the RAS-only to normal demotion, the counter wrap at 511, the variant decoding and the set-versus-clear collision.

// File: rtl/dram_refresh_decoder.sv
module dram_refresh_decoder #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             casl_n,
  input  logic             casu_n,
  input  logic             trg_n,
  input  logic             we_n,
  input  logic [1:0]       cbr_sel,
  input  logic [ROW_W-1:0] ext_row,
  input  logic             set_wpb,
  input  logic             set_stop,
  output logic             in_cycle,
  output logic [1:0]       cycle_kind,
  output logic             refresh_stb,
  output logic [ROW_W-1:0] refresh_row,
  output logic             mode_clear,
  output logic             wpb_on,
  output logic             stop_on,
  output logic             out_hiz
);

  localparam logic [1:0] K_NORM = 2'd0;
  localparam logic [1:0] K_CBR  = 2'd1;
  localparam logic [1:0] K_HID  = 2'd2;
  localparam logic [1:0] K_ROR  = 2'd3;

  logic             ras_q;
  logic             armed;
  logic [ROW_W-1:0] cnt;
  logic [ROW_W-1:0] row_lat;
  logic [1:0]       fall_kind;

  wire cas_any  = !casl_n || !casu_n;
  wire cas_both = !casl_n && !casu_n;
  wire fall     = ras_q && !ras_n;
  wire rise     = !ras_q && ras_n;
  wire opt_rst  = (cbr_sel == 2'b00) || (cbr_sel == 2'b11);
  wire clr_now  = fall && (fall_kind == K_CBR) && opt_rst;

  assign fall_kind = (armed && cas_both) ? K_HID : (cas_any ? K_CBR : K_ROR);
  assign in_cycle  = !ras_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras_q       <= 1'b1;
      armed       <= 1'b0;
      cnt         <= '0;
      row_lat     <= '0;
      cycle_kind  <= K_NORM;
      refresh_stb <= 1'b0;
      refresh_row <= '0;
      mode_clear  <= 1'b0;
      wpb_on      <= 1'b0;
      stop_on     <= 1'b0;
    end else begin
      ras_q       <= ras_n;
      refresh_stb <= 1'b0;
      mode_clear  <= clr_now;
      if (fall) begin
        cycle_kind <= fall_kind;
        row_lat    <= ext_row;
      end else if (rise) begin
        case (cycle_kind)
          K_CBR, K_HID: begin
            refresh_stb <= 1'b1;
            refresh_row <= cnt;
            cnt         <= cnt + 1'b1;
          end
          K_ROR: begin
            refresh_stb <= 1'b1;
            refresh_row <= row_lat;
          end
          default: ;
        endcase
      end else if (in_cycle && cycle_kind == K_ROR && cas_any) begin
        cycle_kind <= K_NORM;
      end
      if (rise)
        armed <= cas_both && ((cycle_kind == K_NORM && we_n) || cycle_kind == K_HID);
      else if (!cas_both)
        armed <= 1'b0;
      if (clr_now) begin
        wpb_on  <= 1'b0;
        stop_on <= 1'b0;
      end else begin
        if (set_wpb)  wpb_on  <= 1'b1;
        if (set_stop) stop_on <= 1'b1;
      end
    end
  end

  always_comb begin
    if (!in_cycle)
      out_hiz = !armed;
    else begin
      case (cycle_kind)
        K_CBR:   out_hiz = 1'b1;
        K_HID:   out_hiz = 1'b0;
        default: out_hiz = !(cas_any && !trg_n);
      endcase
    end
  end

  logic chk_ok = 1'b0;
  always_ff @(posedge clk) chk_ok <= rst_n;

  a_r1_cbr_class: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok && $rose(in_cycle) && cycle_kind == K_CBR |-> $past(!casl_n || !casu_n));

  a_r4_row_step: assert property (@(posedge clk) disable iff (!rst_n)
    chk_ok && cnt != $past(cnt) |-> cnt == $past(cnt) + 1'b1);

  a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    refresh_stb |=> !refresh_stb);

  a_r6_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    mode_clear |-> !wpb_on && !stop_on);

endmodule

// File: tb/test_dram_refresh_decoder.sv
module test_dram_refresh_decoder;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, ras_n, casl_n, casu_n, trg_n, we_n, set_wpb, set_stop;
  logic [1:0] cbr_sel;
  logic [8:0] ext_row;
  logic in_cycle, refresh_stb, mode_clear, wpb_on, stop_on, out_hiz;
  logic [1:0] cycle_kind;
  logic [8:0] refresh_row;

  dram_refresh_decoder #(.ROW_W(9)) i_dram_refresh_decoder (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .casl_n(casl_n), .casu_n(casu_n),
    .trg_n(trg_n), .we_n(we_n), .cbr_sel(cbr_sel), .ext_row(ext_row),
    .set_wpb(set_wpb), .set_stop(set_stop), .in_cycle(in_cycle),
    .cycle_kind(cycle_kind), .refresh_stb(refresh_stb), .refresh_row(refresh_row),
    .mode_clear(mode_clear), .wpb_on(wpb_on), .stop_on(stop_on), .out_hiz(out_hiz));

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural reference
  int m_kind = 0, m_in = 0, m_cnt = 0, m_row = 0, m_stb = 0, m_clr = 0;
  int m_wpb = 0, m_stop = 0, m_arm = 0, m_rasq = 1, m_lat = 0;

  always @(posedge clk) begin
    bit any, both, fall, rise;
    any  = !casl_n || !casu_n;
    both = !casl_n && !casu_n;
    if (!rst_n) begin
      m_kind = 0; m_in = 0; m_cnt = 0; m_row = 0; m_stb = 0; m_clr = 0;
      m_wpb = 0; m_stop = 0; m_arm = 0; m_rasq = 1; m_lat = 0;
    end else begin
      int old_kind;
      old_kind = m_kind;
      fall = (m_rasq == 1) && !ras_n;
      rise = (m_rasq == 0) && ras_n;
      m_stb = 0; m_clr = 0;
      if (fall) begin
        m_kind = (m_arm && both) ? 2 : (any ? 1 : 3);
        m_in = 1;
        m_lat = ext_row;
        if (m_kind == 1 && (cbr_sel == 2'b00 || cbr_sel == 2'b11)) m_clr = 1;
      end else if (rise) begin
        m_in = 0;
        if (m_kind == 1 || m_kind == 2) begin
          m_stb = 1; m_row = m_cnt; m_cnt = (m_cnt + 1) % 512;
        end else if (m_kind == 3) begin
          m_stb = 1; m_row = m_lat;
        end
      end else if (m_in && m_kind == 3 && any) m_kind = 0;
      if (rise) m_arm = both && ((old_kind == 0 && we_n) || old_kind == 2);
      else if (!both) m_arm = 0;
      if (m_clr) begin m_wpb = 0; m_stop = 0; end
      else begin
        if (set_wpb) m_wpb = 1;
        if (set_stop) m_stop = 1;
      end
      m_rasq = ras_n;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int hz;
    if (!m_in) hz = !m_arm;
    else if (m_kind == 1) hz = 1;
    else if (m_kind == 2) hz = 0;
    else hz = !((!casl_n || !casu_n) && !trg_n);
    chk(in_cycle == m_in, "R1 in_cycle", in_cycle, m_in);
    chk(cycle_kind == m_kind, "R1 cycle_kind", cycle_kind, m_kind);
    chk(refresh_stb == m_stb, "R5 refresh_stb", refresh_stb, m_stb);
    chk(refresh_row == m_row, "R5 refresh_row", refresh_row, m_row);
    chk(mode_clear == m_clr, "R6 mode_clear", mode_clear, m_clr);
    chk(wpb_on == m_wpb, "R7 wpb_on", wpb_on, m_wpb);
    chk(stop_on == m_stop, "R7 stop_on", stop_on, m_stop);
    chk(out_hiz == hz, "R8 out_hiz", out_hiz, hz);
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic cbr(input logic [1:0] sel);
    casl_n = 0; tick(1);
    ras_n = 0; cbr_sel = sel; tick(2);
    ras_n = 1; tick(1);
    casl_n = 1; tick(1);
  endtask

  task automatic ror(input logic [8:0] r);
    ext_row = r; ras_n = 0; tick(2);
    ras_n = 1; tick(2);
  endtask

  initial begin
    rst_n = 0; ras_n = 1; casl_n = 1; casu_n = 1; trg_n = 1; we_n = 1;
    cbr_sel = 0; ext_row = 0; set_wpb = 0; set_stop = 0;
    tick(3);
    rst_n = 1; #1;
    chk(in_cycle == 0 && refresh_stb == 0 && wpb_on == 0 && stop_on == 0 && refresh_row == 0,
        "R9 reset state", {in_cycle, refresh_stb, wpb_on, stop_on}, 0);
    tick(1);
    // counter wrap
    for (int i = 0; i < 511; i++) cbr(2'b01);
    casu_n = 0; tick(1); ras_n = 0; cbr_sel = 2'b10; tick(2); ras_n = 1; tick(1);
    chk(refresh_stb == 1 && refresh_row == 511, "R4 row 511", refresh_row, 511);
    casu_n = 1; tick(1);
    cbr(2'b01);
    ror(9'h0aa);
    cbr(2'b01);
    // option reset vs no-reset and flags
    set_wpb = 1; set_stop = 1; tick(1); set_wpb = 0; set_stop = 0; tick(1);
    cbr(2'b01); cbr(2'b10);
    chk(wpb_on && stop_on, "R6 no-reset keeps flags", {wpb_on, stop_on}, 3);
    cbr(2'b11);
    chk(!wpb_on && !stop_on, "R6 code 11 clears", {wpb_on, stop_on}, 0);
    set_wpb = 1; tick(1); set_wpb = 0;
    casl_n = 0; casu_n = 0; tick(1);
    ras_n = 0; cbr_sel = 2'b00; set_stop = 1; tick(1); set_stop = 0;
    chk(!wpb_on && !stop_on && mode_clear, "R7 clear beats set", {wpb_on, stop_on, mode_clear}, 1);
    tick(1); ras_n = 1; tick(1); casl_n = 1; casu_n = 1; tick(1);
    // RAS-only then demoted to normal
    ror(9'h155);
    ext_row = 9'h033; ras_n = 0; tick(1);
    chk(cycle_kind == 3, "R2 RAS-only at fall", cycle_kind, 3);
    casl_n = 0; trg_n = 0; tick(1);
    chk(cycle_kind == 0 && !out_hiz, "R2 demoted normal", cycle_kind, 0);
    ras_n = 1; tick(1);
    chk(!refresh_stb, "R5 no strobe for normal", refresh_stb, 0);
    casl_n = 1; trg_n = 1; tick(1);
    // read then hidden refresh
    ras_n = 0; tick(1); casl_n = 0; casu_n = 0; trg_n = 0; tick(2);
    ras_n = 1; tick(1);
    chk(!out_hiz, "R8 read data held", out_hiz, 0);
    ras_n = 0; tick(1);
    chk(cycle_kind == 2 && !out_hiz, "R3 hidden", cycle_kind, 2);
    tick(1); ras_n = 1; tick(1);
    ras_n = 0; tick(1);
    chk(cycle_kind == 2, "R3 second hidden", cycle_kind, 2);
    ras_n = 1; tick(1); casl_n = 1; casu_n = 1; trg_n = 1; tick(1);
    // write cycle does not arm hidden
    ras_n = 0; tick(1); casl_n = 0; casu_n = 0; we_n = 0; tick(2);
    ras_n = 1; tick(1); ras_n = 0; tick(1);
    chk(cycle_kind == 1 && out_hiz, "R3 write gives CBR", cycle_kind, 1);
    ras_n = 1; we_n = 1; tick(1); casl_n = 1; casu_n = 1; tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #700000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule